// File: doc/BRIEF.md
# Four-Lane Double-Data-Rate Hit Word Serializer

This block is the output stage of a detector readout chip that runs in push mode. Channel logic offers 64-bit hit words over a valid/ready handshake. Each accepted word is sent whole on one of four serial lanes, two bits per clock: one bit for the rising edge and one for the falling edge. A word therefore takes 32 data cycles. The four lanes run independently, so up to four words are in flight at once. There is no request from downstream, and a word starts as soon as a lane can take it. Each lane presents a rise-bit and a fall-bit per cycle, which an external double-data-rate output cell turns into the line signal.

When a lane has no word to send, it repeats a fixed idle pair so that the receiver can lock onto it. Every word is preceded by one start cycle whose pair cannot appear in the idle stream. The busy flag and beat counter of each lane are held in three copies with majority voting, so a single upset copy is outvoted and rewritten on the next edge. When the channel logic offers a word while every lane is occupied, a flag is raised for one cycle. The offered word stays pending until a lane frees up.

Top module: `hit_ddr_serializer`

## Requirements
- R1: While reset is asserted, every lane shows rise=1, fall=0, `in_ready` is 1 and `ovf` is 0.
- R2: A word accepted on a rising edge (`in_valid` and `in_ready` both high) goes to the lowest-numbered lane that is free at that edge. A lane is free when it is idle or in its 32nd data cycle.
- R3: In the cycle after acceptance, the chosen lane shows the start pair rise=0, fall=1.
- R4: In data cycle k (k = 1..32) after the start cycle, the lane shows rise = word bit 65-2k and fall = word bit 64-2k. The word therefore goes out most significant bit first, with the higher bit of each pair on the rising edge.
- R5: A lane with no frame in progress shows the idle pair rise=1, fall=0 in every cycle.
- R6: `in_ready` is 0 exactly when all four lanes are occupied and none is in its 32nd data cycle.
- R7: `ovf` is 1 in the cycle after a cycle with `in_valid`=1 and `in_ready`=0, and 0 after any other cycle.
- R8: A lane that accepts a word during its 32nd data cycle shows the start pair in the very next cycle, with no idle cycle in between.
- R9: Loading or running one lane never changes the pairs shown on any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A hit word is offered |
| in_ready | output | 1 | A lane can take the offered word on this edge |
| in_word | input | 64 | Hit word |
| lane_rise | output | 4 | Per-lane bit for the rising edge |
| lane_fall | output | 4 | Per-lane bit for the falling edge |
| ovf | output | 1 | A word was offered while all lanes were occupied in the previous cycle |

## Verification
Two events can fall on the same edge: a lane finishes its last data pair, and a new word is accepted. In that case the finishing lane must count as free and may win the lane choice against higher-numbered idle lanes. It must also emit its start pair with no idle gap. The bench provokes this with a stretch of continuous offers, which keeps all four lanes saturated and stalls the input. Every pair on every lane is judged against a behavioural model of lane occupancy on every clock, and the bench confirms that such back-to-back reloads and overflow stalls actually occurred.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  // {rise, fall} pairs that frame the serial stream
  localparam logic [1:0] PAIR_IDLE  = 2'b10;
  localparam logic [1:0] PAIR_START = 2'b01;
endpackage

// File: rtl/hsr_vote.sv
module hsr_vote #(
  parameter int W = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/hsr_pick.sv
module hsr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] free,
  output logic [N-1:0] grant,
  output logic         any
);
  // isolate lowest set bit: lowest-numbered free lane wins
  assign grant = free & (~free + N'(1));
  assign any   = |free;
endmodule

// File: rtl/hsr_lane.sv
module hsr_lane
  import hsr_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BEATS  = WORD_W / 2,
  parameter int CNT_W  = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              free,
  output logic              rise,
  output logic              fall
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS);

  // triplicated control state
  logic [2:0]       busy_q;
  logic [CNT_W-1:0] cnt_q [3];
  logic             busy_v;
  logic [CNT_W-1:0] cnt_v;

  logic              busy_d;
  logic [CNT_W-1:0]  cnt_d;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_d;
  logic              sh_en;

  hsr_vote #(.W(1)) u_vote_busy (
    .a(busy_q[0]), .b(busy_q[1]), .c(busy_q[2]), .y(busy_v)
  );
  hsr_vote #(.W(CNT_W)) u_vote_cnt (
    .a(cnt_q[0]), .b(cnt_q[1]), .c(cnt_q[2]), .y(cnt_v)
  );

  // next state
  always_comb begin
    busy_d = busy_v;
    cnt_d  = cnt_v;
    sh_en  = 1'b0;
    sh_d   = sh_q << 2;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sh_en  = 1'b1;
      sh_d   = word;
    end else if (busy_v) begin
      sh_en = (cnt_v != '0);
      if (cnt_v == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_v + CNT_W'(1);
      end
    end
  end

  // control registers, every copy rewritten from the voted value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        busy_q[c] <= 1'b0;
        cnt_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        busy_q[c] <= busy_d;
        cnt_q[c]  <= cnt_d;
      end
    end
  end

  // data shift register, no reset needed
  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= sh_d;
  end

  assign busy = busy_v;
  assign free = ~busy_v | (cnt_v == LAST);

  always_comb begin
    if (!busy_v)            {rise, fall} = PAIR_IDLE;
    else if (cnt_v == '0)   {rise, fall} = PAIR_START;
    else                    {rise, fall} = sh_q[WORD_W-1 -: 2];
  end
endmodule

// File: rtl/hit_ddr_serializer.sv
module hit_ddr_serializer #(
  parameter int WORD_W = 64,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [LANES-1:0]  lane_rise,
  output logic [LANES-1:0]  lane_fall,
  output logic              ovf
);
  localparam int BEATS = WORD_W / 2;
  localparam int CNT_W = $clog2(BEATS + 1);

  logic [LANES-1:0] lane_free;
  logic [LANES-1:0] lane_busy;
  logic [LANES-1:0] grant;
  logic [LANES-1:0] load;
  logic             ovf_d;

  hsr_pick #(.N(LANES)) u_pick (
    .free (lane_free),
    .grant(grant),
    .any  (in_ready)
  );

  assign load = grant & {LANES{in_valid}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    hsr_lane #(.WORD_W(WORD_W), .BEATS(BEATS), .CNT_W(CNT_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load[i]),
      .word (in_word),
      .busy (lane_busy[i]),
      .free (lane_free[i]),
      .rise (lane_rise[i]),
      .fall (lane_fall[i])
    );
  end

  assign ovf_d = in_valid & ~in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= ovf_d;
  end
endmodule

// File: rtl/hit_ddr_serializer_chk.sv
module hit_ddr_serializer_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] lane_rise,
  input logic [LANES-1:0] lane_fall,
  input logic             ovf,
  input logic [LANES-1:0] load,
  input logic [LANES-1:0] busy
);
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load)); // R2

  AST_READY_LOW_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (&busy)); // R6

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf); // R7

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_ready) |=> !ovf); // R7

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    AST_START_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      load[i] |=> (!lane_rise[i] && lane_fall[i])); // R3

    AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[i] |-> (lane_rise[i] && !lane_fall[i])); // R5
  end
endmodule

bind hit_ddr_serializer hit_ddr_serializer_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .lane_rise(lane_rise),
  .lane_fall(lane_fall),
  .ovf      (ovf),
  .load     (load),
  .busy     (lane_busy)
);

// File: tb/hit_ddr_serializer_test.sv
`timescale 1ns/1ps
module hit_ddr_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic [3:0]  lane_rise;
  logic [3:0]  lane_fall;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hit_ddr_serializer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .lane_rise(lane_rise), .lane_fall(lane_fall), .ovf(ovf)
  );

  always #5 clk = ~clk;

  // behavioural reference: per-lane position (-1 idle, 0 start, 1..32 data)
  int          pos [4] = '{-1, -1, -1, -1};
  int          last_pos [4] = '{-1, -1, -1, -1};
  logic [63:0] wd [4];
  bit          ovf_m = 0;
  bit          took = 0;
  int          b2b_events = 0;
  int          ovf_events = 0;
  int          lane3_loads = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) pos[l] = -1;
      ovf_m = 0;
      took = 0;
    end else begin
      int sel;
      sel = -1;
      for (int l = 0; l < 4; l++)
        if (sel < 0 && (pos[l] < 0 || pos[l] == 32)) sel = l;
      took  = in_valid && (sel >= 0);
      ovf_m = in_valid && (sel < 0);
      if (ovf_m) ovf_events++;
      for (int l = 0; l < 4; l++) begin
        if (took && l == sel) begin
          if (pos[l] == 32) b2b_events++;
          if (l == 3) lane3_loads++;
          pos[l] = 0;
          wd[l]  = in_word;
        end else if (pos[l] == 32) pos[l] = -1;
        else if (pos[l] >= 0) pos[l] = pos[l] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit ready_model();
    bit r;
    r = 0;
    for (int l = 0; l < 4; l++) if (pos[l] < 0 || pos[l] == 32) r = 1;
    return r;
  endfunction

  task automatic compare_all();
    for (int l = 0; l < 4; l++) begin
      int er, ef, p;
      p = pos[l];
      if (p < 0) begin er = 1; ef = 0; end
      else if (p == 0) begin er = 0; ef = 1; end
      else begin er = int'(wd[l][65-2*p]); ef = int'(wd[l][64-2*p]); end
      // a wrong lane choice shows up as a mismatch here (R2, R9)
      if (p < 0)
        check({lane_rise[l], lane_fall[l]} == {er[0], ef[0]}, "R5", $sformatf("idle pair lane%0d", l),
              {lane_rise[l], lane_fall[l]}, {er[0], ef[0]});
      else if (p == 0)
        check({lane_rise[l], lane_fall[l]} == {er[0], ef[0]},
              (last_pos[l] == 32) ? "R8" : "R3", $sformatf("start pair lane%0d", l),
              {lane_rise[l], lane_fall[l]}, {er[0], ef[0]});
      else
        check({lane_rise[l], lane_fall[l]} == {er[0], ef[0]}, "R4",
              $sformatf("data pair lane%0d beat%0d (R2 R9 lane choice)", l, p),
              {lane_rise[l], lane_fall[l]}, {er[0], ef[0]});
      last_pos[l] = p;
    end
    check(in_ready == ready_model(), "R6", "in_ready", in_ready, ready_model());
    check(ovf == ovf_m, "R7", "ovf", ovf, ovf_m);
  endtask

  initial begin
    int n_sent, rate;
    n_sent = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lane_rise == 4'hF && lane_fall == 4'h0, "R1", "reset pairs",
          {lane_rise, lane_fall}, 8'hF0);
    check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    check(ovf == 1'b0, "R1", "reset ovf", ovf, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3600; cyc++) begin
      @(negedge clk);
      compare_all();
      if (cyc < 300)       rate = 3;
      else if (cyc < 1300) rate = 100;
      else if (cyc < 2300) rate = 12;
      else if (cyc < 3300) rate = 60;
      else                 rate = 0;
      if (!in_valid || took) begin
        if (in_valid && took) n_sent++;
        if ($urandom_range(99) < rate) begin
          in_valid = 1'b1;
          case (n_sent)
            0: in_word = 64'h8000_0000_0000_0001;
            1: in_word = 64'hFFFF_FFFF_FFFF_FFFF;
            2: in_word = 64'h0000_0000_0000_0000;
            3: in_word = 64'hAAAA_AAAA_5555_5555;
            default: in_word = {$urandom, $urandom};
          endcase
        end else begin
          in_valid = 1'b0;
        end
      end
    end
    check(b2b_events > 0, "R8", "back-to-back reloads seen", b2b_events, 1);
    check(ovf_events > 0, "R7", "overflow stalls seen", ovf_events, 1);
    check(lane3_loads > 0, "R9", "highest lane used", lane3_loads, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule